// File: doc/BRIEF.md
# Interrupt Steering Aggregator

This block gathers a parameterised number of 32-bit words of level-sensitive interrupt sources and reduces them to one parent interrupt line. Software controls it through a small register bus. Each word has three registers: an enable mask, a software set register that can raise sources, and a read-only status register that shows which unmasked sources are pending. A one-bit channel enable gates the parent output. A one-bit master disable suppresses it. A summary register has one bit per word and shows at a glance which words carry pending work.

The register layout is computed from the word count `NUM_WORDS`. The word registers sit in three back-to-back groups of `NUM_WORDS` entries each. The master disable and summary registers follow the last group. A build-time flag, `REVERSE`, stores logical word i at physical register index `NUM_WORDS-1-i`. This suits integrations where software expects the highest word first. Sources have no acknowledge: a pending bit lasts exactly as long as its cause.

Top module: `irq_steer_top`

## Requirements
- R1: After reset every register is zero, `irqOut` is low and every readable offset returns zero.
- R2: Byte offset 0x0 is the channel control register. Its bit 0 is the channel enable, and `irqOut` stays low while the enable is 0.
- R3: The mask register of physical word p is at offset 0x4+4p. A 1 in bit b unmasks that source and a 0 masks it.
- R4: The set register of physical word p is at offset 0x4+4p+4*NUM_WORDS. A 1 in bit b raises that source exactly as the input pin would.
- R5: The status register of physical word p is at offset 0x4+4p+8*NUM_WORDS and reads (input OR set) AND mask for that word. It is level-following with no acknowledge, and writes to it are ignored.
- R6: Source number s is input bit s of `srcIrq`. It belongs to logical word s/32, bit s%32, so source 31 is bit 31 of word 0 and source 32 is bit 0 of word 1.
- R7: With `REVERSE`=0, logical word i uses physical index i. With `REVERSE`=1 it uses physical index NUM_WORDS-1-i for its mask, set and status registers.
- R8: The master disable register is at offset 0x4+12*NUM_WORDS. Its bit 0 set to 1 forces `irqOut` low.
- R9: The summary register is at offset 0x8+12*NUM_WORDS. Bit i is 1 when logical word i has any status bit set, so it reads zero when nothing is pending.
- R10: `irqOut` is registered and equals, one clock later, channel enable AND (summary != 0) AND NOT master disable.
- R11: A read strobe returns data on `busRdData` one clock later. With no read strobe, `busRdData` is zero. Offsets that are unmapped or not word-aligned read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIrq | input | 32*NUM_WORDS | Level-sensitive interrupt sources |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, valid the clock after the strobe |
| irqOut | output | 1 | Parent interrupt |

## Verification
The bench builds two copies with three words each, one in natural order and one in reversed order, and drives both with the same bus traffic and sources. Three words is the smallest count that keeps a middle word fixed while the two outer words swap. A single write therefore lands on different logical words in the two copies, which exposes any slip in the reversal. The source pattern includes bits 31, 32 and 95 to cover the word boundaries and the top of the vector. The address sweep runs past the summary register and includes misaligned offsets.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CTRL,
    RD_MASK,
    RD_SET,
    RD_STAT,
    RD_MDIS,
    RD_MSTAT
  } rdKind_e;

  localparam int STROBE_IDX_W = 8;

  typedef struct packed {
    logic                    wrCtrl;
    logic                    wrMask;
    logic                    wrSet;
    logic                    wrMdis;
    rdKind_e                 rdKind;
    logic [STROBE_IDX_W-1:0] idx;
  } regStrobe_t;

endpackage

// File: rtl/irq_steer_decode.sv
module irq_steer_decode
  import irq_steer_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output regStrobe_t        strobe
);

  localparam int SET_BASE  = NUM_WORDS + 1;
  localparam int STAT_BASE = 2 * NUM_WORDS + 1;
  localparam int MDIS_SLOT = 3 * NUM_WORDS + 1;
  localparam int MSTAT_SLOT = 3 * NUM_WORDS + 2;

  logic [ADDR_W-3:0] wordAddr;
  logic              aligned;
  rdKind_e           kind;
  int                slot;

  assign wordAddr = busAddr[ADDR_W-1:2];
  assign aligned  = (busAddr[1:0] == 2'b00);

  always_comb begin
    slot = int'(wordAddr);
    kind = RD_NONE;
    strobe.idx = '0;
    if (aligned) begin
      if (slot == 0) begin
        kind = RD_CTRL;
      end else if (slot < SET_BASE) begin
        kind = RD_MASK;
        strobe.idx = STROBE_IDX_W'(slot - 1);
      end else if (slot < STAT_BASE) begin
        kind = RD_SET;
        strobe.idx = STROBE_IDX_W'(slot - SET_BASE);
      end else if (slot < MDIS_SLOT) begin
        kind = RD_STAT;
        strobe.idx = STROBE_IDX_W'(slot - STAT_BASE);
      end else if (slot == MDIS_SLOT) begin
        kind = RD_MDIS;
      end else if (slot == MSTAT_SLOT) begin
        kind = RD_MSTAT;
      end
    end
    strobe.wrCtrl = busWrEn && (kind == RD_CTRL);
    strobe.wrMask = busWrEn && (kind == RD_MASK);
    strobe.wrSet  = busWrEn && (kind == RD_SET);
    strobe.wrMdis = busWrEn && (kind == RD_MDIS);
    strobe.rdKind = busRdEn ? kind : RD_NONE;
  end

endmodule

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
  import irq_steer_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter bit REVERSE   = 1'b0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [32*NUM_WORDS-1:0] srcIrq,
  input  logic [31:0]             busWrData,
  input  regStrobe_t              strobe,
  output logic [31:0]             busRdData,
  output logic                    irqOut,
  output logic                    enBit,
  output logic                    mdisBit,
  output logic                    anyPend
);

  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic [31:0]          maskPhys [NUM_WORDS];
  logic [31:0]          setPhys  [NUM_WORDS];
  logic [31:0]          statPhys [NUM_WORDS];
  logic [NUM_WORDS-1:0] summary;
  logic [IDX_W-1:0]     sel;
  logic [31:0]          rdVal;

  assign sel = strobe.idx[IDX_W-1:0];

  // Status and summary per logical word, placed at its physical slot
  for (genvar g = 0; g < NUM_WORDS; g++) begin : gWord
    localparam int PHYS = REVERSE ? (NUM_WORDS - 1 - g) : g;
    assign statPhys[PHYS] = (srcIrq[32*g +: 32] | setPhys[PHYS]) & maskPhys[PHYS];
    assign summary[g]     = |statPhys[PHYS];
  end

  assign anyPend = |summary;

  always_comb begin
    rdVal = '0;
    case (strobe.rdKind)
      RD_CTRL:  rdVal[0] = enBit;
      RD_MASK:  rdVal = maskPhys[sel];
      RD_SET:   rdVal = setPhys[sel];
      RD_STAT:  rdVal = statPhys[sel];
      RD_MDIS:  rdVal[0] = mdisBit;
      RD_MSTAT: rdVal[NUM_WORDS-1:0] = summary;
      default:  rdVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit     <= 1'b0;
      mdisBit   <= 1'b0;
      irqOut    <= 1'b0;
      busRdData <= '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
        maskPhys[w] <= '0;
        setPhys[w]  <= '0;
      end
    end else begin
      irqOut    <= enBit & anyPend & ~mdisBit;
      busRdData <= rdVal;
      if (strobe.wrCtrl) enBit   <= busWrData[0];
      if (strobe.wrMdis) mdisBit <= busWrData[0];
      if (strobe.wrMask) maskPhys[sel] <= busWrData;
      if (strobe.wrSet)  setPhys[sel]  <= busWrData;
    end
  end

endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
  import irq_steer_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter bit REVERSE   = 1'b0,
  parameter int ADDR_W    = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [32*NUM_WORDS-1:0] srcIrq,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busWrEn,
  input  logic [31:0]             busWrData,
  input  logic                    busRdEn,
  output logic [31:0]             busRdData,
  output logic                    irqOut
);

  regStrobe_t strobe;
  logic       enBit;
  logic       mdisBit;
  logic       anyPend;

  irq_steer_decode #(
    .NUM_WORDS(NUM_WORDS),
    .ADDR_W   (ADDR_W)
  ) u_decode (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .strobe (strobe)
  );

  irq_steer_regs #(
    .NUM_WORDS(NUM_WORDS),
    .REVERSE  (REVERSE)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .srcIrq   (srcIrq),
    .busWrData(busWrData),
    .strobe   (strobe),
    .busRdData(busRdData),
    .irqOut   (irqOut),
    .enBit    (enBit),
    .mdisBit  (mdisBit),
    .anyPend  (anyPend)
  );

endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busRdEn,
  input logic [31:0] busRdData,
  input logic        irqOut,
  input logic        enBit,
  input logic        mdisBit,
  input logic        anyPend
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !irqOut);

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == $past(enBit && anyPend && !mdisBit));

  // R2
  no_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |=> !irqOut);

  // R8
  mdis_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    mdisBit |=> !irqOut);

  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> busRdData == 32'h0);

endmodule

bind irq_steer_top irq_steer_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busRdEn  (busRdEn),
  .busRdData(busRdData),
  .irqOut   (irqOut),
  .enBit    (enBit),
  .mdisBit  (mdisBit),
  .anyPend  (anyPend)
);

// File: tb/irq_steer_top_bench.sv
`timescale 1ns/1ps
module irq_steer_top_bench;

  localparam int NW = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [95:0] srcIrq = '0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] rdData [2];
  logic        irq [2];

  int    errors = 0;
  int    checks = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  irq_steer_top #(.NUM_WORDS(NW), .REVERSE(1'b0), .ADDR_W(8)) u_irq_steer_top (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdEn(busRdEn),
    .busRdData(rdData[0]), .irqOut(irq[0])
  );

  irq_steer_top #(.NUM_WORDS(NW), .REVERSE(1'b1), .ADDR_W(8)) u_irq_steer_top_rev (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdEn(busRdEn),
    .busRdData(rdData[1]), .irqOut(irq[1])
  );

  // Reference model state, index 0 natural order, index 1 reversed
  logic [31:0] mMask [2][NW];
  logic [31:0] mSet  [2][NW];
  bit          mEn   [2];
  bit          mMdis [2];
  bit          mIrq  [2];
  logic [31:0] mRd   [2];

  function automatic logic [31:0] modelStat(int d, int p);
    int lw;
    lw = (d == 1) ? (NW - 1 - p) : p;
    return (srcIrq[32*lw +: 32] | mSet[d][p]) & mMask[d][p];
  endfunction

  function automatic logic [31:0] modelSummary(int d);
    logic [31:0] s;
    s = '0;
    for (int lw = 0; lw < NW; lw++) begin
      int p;
      p = (d == 1) ? (NW - 1 - lw) : lw;
      if (modelStat(d, p) != 0) s[lw] = 1'b1;
    end
    return s;
  endfunction

  function automatic logic [31:0] modelRead(int d, int a);
    int w;
    if (a % 4 != 0) return 32'h0;
    w = a / 4;
    if (w == 0) return {31'h0, mEn[d]};
    if (w <= NW) return mMask[d][w-1];
    if (w <= 2*NW) return mSet[d][w-1-NW];
    if (w <= 3*NW) return modelStat(d, w-1-2*NW);
    if (w == 3*NW+1) return {31'h0, mMdis[d]};
    if (w == 3*NW+2) return modelSummary(d);
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int d = 0; d < 2; d++) begin
        mEn[d] <= 1'b0; mMdis[d] <= 1'b0; mIrq[d] <= 1'b0; mRd[d] <= '0;
        for (int p = 0; p < NW; p++) begin
          mMask[d][p] <= '0; mSet[d][p] <= '0;
        end
      end
    end else begin
      for (int d = 0; d < 2; d++) begin
        int w;
        mIrq[d] <= mEn[d] && (modelSummary(d) != 0) && !mMdis[d];
        mRd[d]  <= busRdEn ? modelRead(d, int'(busAddr)) : 32'h0;
        w = int'(busAddr) / 4;
        if (busWrEn && busAddr[1:0] == 2'b00) begin
          if (w == 0) mEn[d] <= busWrData[0];
          else if (w <= NW) mMask[d][w-1] <= busWrData;
          else if (w <= 2*NW) mSet[d][w-1-NW] <= busWrData;
          else if (w == 3*NW+1) mMdis[d] <= busWrData[0];
        end
      end
    end
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      for (int d = 0; d < 2; d++) begin
        checks++;
        if (irq[d] !== mIrq[d]) begin
          errors++;
          $display("FAIL %s dut%0d irqOut actual=%0b expected=%0b", tag, d, irq[d], mIrq[d]);
        end
        checks++;
        if (rdData[d] !== mRd[d]) begin
          errors++;
          $display("FAIL %s dut%0d busRdData actual=%h expected=%h", tag, d, rdData[d], mRd[d]);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] v);
    @(negedge clk);
    busAddr = 8'(a); busWrData = v; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    busAddr = 8'(a); busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic readAll();
    for (int a = 0; a < 56; a += 4) rd(a);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    // R1: reset state, every offset reads zero
    tag = "R1";
    idle(3);
    rstN = 1'b1;
    srcIrq = {32'h8000_0000, 32'h0000_0001, 32'h8000_0001};
    readAll();

    // R3 / R6: unmask boundary sources 0, 31, 32, 95 via physical slots
    tag = "R3";
    wr(32'h04, 32'h8000_0001);
    wr(32'h08, 32'h0000_0001);
    tag = "R6";
    readAll();
    wr(32'h0C, 32'h8000_0000);
    readAll();

    // R2: channel enable gates the parent line
    tag = "R2";
    idle(3);
    wr(32'h00, 32'h1);
    idle(3);
    rd(32'h00);

    // R10: output follows pending set by one clock
    tag = "R10";
    srcIrq = '0;
    idle(3);
    srcIrq[95] = 1'b1;
    idle(3);
    srcIrq[95] = 1'b0;
    idle(2);

    // R4: software set raises sources like an input
    tag = "R4";
    wr(32'h04, 32'hFFFF_FFFF);
    wr(32'h08, 32'hFFFF_FFFF);
    wr(32'h0C, 32'hFFFF_FFFF);
    wr(32'h14, 32'h0000_00F0);
    readAll();
    wr(32'h14, 32'h0);
    idle(2);

    // R5: status is read-only and level-following
    tag = "R5";
    srcIrq[40] = 1'b1;
    wr(32'h20, 32'hFFFF_FFFF);
    wr(32'h1C, 32'hFFFF_FFFF);
    readAll();
    srcIrq[40] = 1'b0;
    readAll();

    // R7: a write to physical slot 0 serves word 0 or word 2
    tag = "R7";
    wr(32'h08, 32'h0);
    wr(32'h0C, 32'h0);
    wr(32'h04, 32'h0000_0100);
    srcIrq = '0;
    srcIrq[72] = 1'b1;
    idle(3);
    readAll();
    srcIrq[72] = 1'b0;
    srcIrq[8]  = 1'b1;
    idle(3);
    readAll();

    // R8: master disable blocks the line, clearing restores it
    tag = "R8";
    wr(32'h28, 32'h1);
    idle(3);
    rd(32'h28);
    wr(32'h28, 32'h0);
    idle(3);

    // R9: summary per word, zero with nothing pending
    tag = "R9";
    wr(32'h10, 32'h0000_0002);
    wr(32'h18, 32'h0000_0004);
    rd(32'h2C);
    srcIrq = '0;
    wr(32'h10, 32'h0);
    wr(32'h18, 32'h0);
    rd(32'h2C);

    // R11: unmapped and misaligned offsets
    tag = "R11";
    wr(32'h30, 32'hFFFF_FFFF);
    wr(32'h01, 32'hFFFF_FFFF);
    wr(32'h05, 32'h0);
    wr(32'hFC, 32'hFFFF_FFFF);
    rd(32'h30);
    rd(32'h01);
    rd(32'h06);
    rd(32'hFC);
    readAll();
    idle(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule